// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence for a four-beat burst. Either of two load strobes captures a base address and starts a burst. One strobe is for the processor side and the other is for the controller side. A two-bit beat counter then steps once on every cycle in which the advance input is high.

The upper address bits pass through unchanged from the captured base. The two low bits come from the captured low bits combined with the beat counter. A mode input picks how they combine:
- a wrapping linear order, where the low bits are the sum modulo four;
- an interleaved order, where the low bits are the exclusive-OR, as some processor cache-line fills expect.

The output is formed combinationally from the stored base and counter. A captured address therefore appears on the cycle after the strobe edge. The mode input acts on the output without waiting for a clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While the active-low reset `rst_n` is low, `addr_out` is all zeros. The beat counter is cleared, so the first advance after reset yields address 1.
- R2: A clock edge with `load_cpu` or `load_ctl` high, or with both high, captures `addr_in`. After that edge, `addr_out` equals the captured address in both orders.
- R3: A load has priority over `advance`. A load edge with `advance` high still yields beat 0.
- R4: With no load and `advance` low, a clock edge leaves `addr_out` unchanged, provided `order_xor` is steady.
- R5: With `order_xor` = 0 (linear), `addr_out[1:0]` equals (captured low bits + beat count) mod 4.
- R6: With `order_xor` = 1 (interleaved), `addr_out[1:0]` equals the captured low bits XOR the beat count.
- R7: The beat count wraps from 3 to 0. Each fourth consecutive advance returns `addr_out` to the captured address.
- R8: `addr_out[ADDR_W-1:2]` holds the captured upper bits for the whole burst. There is no carry out of the low bits, and `addr_in` is ignored on edges without a load.
- R9: A change of `order_xor` in mid-burst re-maps the current beat count at once. No reload is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_cpu | input | 1 | Processor-side load strobe |
| load_ctl | input | 1 | Controller-side load strobe |
| advance | input | 1 | Step the beat counter |
| order_xor | input | 1 | 0 = linear wrap order, 1 = interleaved order |
| addr_in | input | ADDR_W | Address captured on a load |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The step and hold properties assume that `order_xor` is steady across the edge they look at. When the mode changes on that edge, each property accepts the new mapping in place of the stepped or held value.

The vector table changes `order_xor` only in positions where the expected value is computed for the new mode. One such vector is a deliberate mid-burst switch for R9.

All load, hold and advance vectors use `order_xor` together with base low bits of 01 or 11. For those values the linear and interleaved sequences differ, so an error in the order cannot stay hidden. In particular, a base with low bits 10 gives the same sequence in both orders.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cpu,
  input  logic              load_ctl,
  input  logic              advance,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic              load;
  logic [CNT_W-1:0]  lin_low, xor_low;

  assign load = load_cpu | load_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (advance) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign lin_low  = base_q[CNT_W-1:0] + beat_q;
  assign xor_low  = base_q[CNT_W-1:0] ^ beat_q;
  assign addr_out = {base_q[ADDR_W-1 -: HI_W], order_xor ? xor_low : lin_low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_cpu,
  input logic              load_ctl,
  input logic              advance,
  input logic              order_xor,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cpu || load_ctl) |=> addr_out == $past(addr_in));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_cpu || load_ctl) && advance) |=> addr_out == $past(addr_in));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cpu && !load_ctl && !advance) |=>
      (addr_out == $past(addr_out)) || (order_xor != $past(order_xor)));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cpu && !load_ctl && advance && !order_xor) |=>
      order_xor || (addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + 1'b1));

  assert_xor_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cpu && !load_ctl && advance && order_xor) |=>
      !order_xor || (addr_out[CNT_W-1:0] != $past(addr_out[CNT_W-1:0])));

  assert_upper_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cpu && !load_ctl) |=>
      addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_cpu(load_cpu), .load_ctl(load_ctl),
  .advance(advance), .order_xor(order_xor), .addr_in(addr_in), .addr_out(addr_out)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 18;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_cpu = 1'b0, load_ctl = 1'b0, advance = 1'b0, order_xor = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  int            n_chk = 0, n_fail = 0;

  // {load_cpu, load_ctl, advance, order_xor, addr_in, expected addr_out}
  localparam logic [4+2*AW-1:0] VEC [NV] = '{
    {4'b1000, 18'h12345, 18'h12345}, // R2 cpu load, linear base 01
    {4'b0010, 18'h00000, 18'h12346}, // R5 beat1
    {4'b0010, 18'h00000, 18'h12347}, // R5 beat2
    {4'b0010, 18'h00000, 18'h12344}, // R5 beat3 wraps low bits, R8 no carry
    {4'b0010, 18'h00000, 18'h12345}, // R7 wrap to beat0
    {4'b0000, 18'h3FFFF, 18'h12345}, // R4 hold, R8 addr_in ignored
    {4'b0010, 18'h3FFFF, 18'h12346}, // R8 addr_in ignored while advancing
    {4'b0111, 18'h0ABCD, 18'h0ABCD}, // R2 ctl load, R3 load beats advance
    {4'b0011, 18'h00000, 18'h0ABCC}, // R6 beat1 01^01
    {4'b0011, 18'h00000, 18'h0ABCF}, // R6 beat2 01^10
    {4'b0011, 18'h00000, 18'h0ABCE}, // R6 beat3 01^11
    {4'b0011, 18'h00000, 18'h0ABCD}, // R7 interleaved wrap
    {4'b0011, 18'h00000, 18'h0ABCC}, // R6 beat1 again
    {4'b0000, 18'h00000, 18'h0ABCE}, // R9 switch to linear at beat1
    {4'b0001, 18'h00000, 18'h0ABCC}, // R9 back to interleaved at beat1
    {4'b1110, 18'h3FFFF, 18'h3FFFF}, // R2 both strobes, R3
    {4'b0010, 18'h00000, 18'h3FFFC}, // R8 upper held, no carry
    {4'b0010, 18'h00000, 18'h3FFFD}, // R5
    {4'b0010, 18'h00000, 18'h3FFFE}, // R5
    {4'b1001, 18'h20003, 18'h20003}, // R2 reload mid-burst, interleaved
    {4'b0011, 18'h00000, 18'h20002}, // R6 11^01
    {4'b0001, 18'h00000, 18'h20002}  // R4 hold in interleaved order
  };

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_cpu(load_cpu), .load_ctl(load_ctl),
    .advance(advance), .order_xor(order_xor), .addr_in(addr_in), .addr_out(addr_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (addr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 18'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {load_cpu, load_ctl, advance, order_xor} = VEC[i][4+2*AW-1 -: 4];
      addr_in = VEC[i][2*AW-1 -: AW];
      @(posedge clk);
      #1;
      check($sformatf("R2-R9 vector %0d", i), VEC[i][AW-1:0]);
    end
    @(negedge clk);
    {load_cpu, load_ctl, advance, order_xor} = 4'b0000;
    rst_n = 1'b0;
    #1;
    check("R1 mid-burst", 18'h0);
    @(negedge clk);
    rst_n = 1'b1;
    advance = 1'b1;
    @(posedge clk);
    #1;
    check("R1 beat cleared", 18'h1);
    @(negedge clk);
    advance = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule